// File: doc/BRIEF.md
# Packed Double to Unsigned Word Converter

This unit converts a vector of 64-bit binary floating-point values into 32-bit unsigned integers, one lane per value. The vector holds 2, 4 or 8 lanes, chosen by a length code. Every lane has its own converter. The converter rounds under a selectable mode. It raises an invalid flag and returns all ones when the rounded value cannot fit in 32 unsigned bits. It raises an inexact flag when rounding changed the value.

A writemask selects which lanes are converted. Each lane that is not selected either keeps its previous destination word (merge) or is cleared (zero). A broadcast bit does one of two things:
- For a memory-sourced operand, it makes every lane read the lowest 64-bit element.
- For a full-length register operand, it lets an instruction-supplied rounding field override the global mode.

A 4-bit operand field that is not all ones marks the operation as undefined. In that case the old destination passes through with no flags. The result, flags and undefined indication are registered on an input strobe and appear one cycle later.

Top module: `pcv_u32_unit`

## Requirements
- R1: `vlen_i` selects the lane count: 2'b00 gives 2 lanes, 2'b01 gives 4, and 2'b10 or 2'b11 give 8. Lane j reads source bits [64j+63:64j] and writes destination bits [32j+31:32j].
- R2: An in-range value is rounded by the effective mode. The codes are 2'b00 nearest-even, 2'b01 toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero. For example, 2.5 gives 2, 2, 3 and 2 in these four modes.
- R3: A lane raises invalid, and writes 32'hFFFFFFFF, when its input is NaN or infinite, or when its rounded value is negative and nonzero, or when its rounded value is at least 2^32. An invalid lane never raises inexact.
- R4: A valid lane raises inexact exactly when its rounded result differs from its input. A negative input that rounds to zero returns 0, with inexact set.
- R5: A lane inside the lane count is converted when `mask_en_i` is 0 or its `wmask_i` bit is 1.
- R6: With `mask_en_i`=1 and `zero_en_i`=0, an unselected lane inside the lane count keeps its `old_dst_i` word.
- R7: With `mask_en_i`=1 and `zero_en_i`=1, an unselected lane inside the lane count is written with 0.
- R8: Every destination bit at or above half the source width is 0. That covers bits [511:256], and the words of lanes beyond the lane count.
- R9: The rounding mode comes from `erc_i` when `src_mem_i`=0, `bcast_i`=1 and `vlen_i`[1]=1. Otherwise it comes from `grc_i`.
- R10: With `src_mem_i`=1 and `bcast_i`=1, every lane converts `src_i`[63:0].
- R11: When `rsvd_i` is not 4'b1111, `ud_o` is 1, `dst_o` equals `old_dst_i`, and both flags are 0. With 4'b1111, `ud_o` is 0.
- R12: `inv_o` and `inx_o` are the OR of the flags of lanes that are inside the lane count and selected. Lanes that are masked off or out of range contribute nothing.
- R13: Outputs reset to 0. `out_valid_o` follows `in_valid_i` one cycle later. The other outputs load only on a cycle with `in_valid_i` high, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation strobe |
| src_i | input | 512 | Packed 64-bit source values |
| src_mem_i | input | 1 | Source is a memory operand |
| bcast_i | input | 1 | Broadcast / rounding override bit |
| vlen_i | input | 2 | Vector length code |
| erc_i | input | 2 | Instruction-supplied rounding mode |
| grc_i | input | 2 | Global rounding mode |
| wmask_i | input | 8 | Per-lane writemask |
| mask_en_i | input | 1 | Writemask in use |
| zero_en_i | input | 1 | Zeroing instead of merging |
| old_dst_i | input | 512 | Previous destination value |
| rsvd_i | input | 4 | Reserved operand field |
| out_valid_o | output | 1 | Result valid |
| dst_o | output | 512 | New destination value |
| inv_o | output | 1 | Invalid flag |
| inx_o | output | 1 | Inexact flag |
| ud_o | output | 1 | Undefined operation |

## Verification
The hardest case to reach is a flag that must be hidden. A lane whose value would raise invalid or inexact, but which is masked off or sits beyond the lane count, must leave the OR-reduced flags clear. Random stimulus rarely lines up a NaN with a cleared mask bit. Directed tasks therefore load special values into chosen lanes and clear exactly those mask bits, or shorten the vector length beneath them. A random sweep then mixes specials, values near the half-way point of rounding, and values near 2^32 against an independent real-arithmetic model.

// File: rtl/pcv_pkg.sv
package pcv_pkg;
  localparam int unsigned FP_W  = 64;
  localparam int unsigned INT_W = 32;

  typedef enum logic [1:0] {
    RC_NEAR = 2'b00,
    RC_DOWN = 2'b01,
    RC_UP   = 2'b10,
    RC_ZERO = 2'b11
  } pcv_rc_e;
endpackage

// File: rtl/pcv_ctl.sv
module pcv_ctl
  import pcv_pkg::*;
#(
  parameter int unsigned NLANE = 8
) (
  input  logic [1:0]       vlen_i,
  input  logic             src_mem_i,
  input  logic             bcast_i,
  input  logic [1:0]       erc_i,
  input  logic [1:0]       grc_i,
  input  logic [3:0]       rsvd_i,
  output logic [NLANE-1:0] lane_on_o,
  output pcv_rc_e          rc_o,
  output logic             bmem_o,
  output logic             ud_o
);
  int unsigned cnt;

  always_comb begin
    case (vlen_i)
      2'b00:   cnt = 2;
      2'b01:   cnt = 4;
      default: cnt = 8;
    endcase
    for (int j = 0; j < NLANE; j++) lane_on_o[j] = (j < cnt);
  end

  // override only for full-length register form with broadcast bit
  assign rc_o   = pcv_rc_e'((!src_mem_i && bcast_i && vlen_i[1]) ? erc_i : grc_i);
  assign bmem_o = src_mem_i && bcast_i;
  assign ud_o   = (rsvd_i != 4'b1111);
endmodule

// File: rtl/pcv_lane_cvt.sv
module pcv_lane_cvt
  import pcv_pkg::*;
(
  input  logic [FP_W-1:0]  op_i,
  input  pcv_rc_e          rc_i,
  output logic [INT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o
);
  localparam logic [10:0] BIAS    = 11'd1023;
  localparam logic [10:0] EXP_LIM = 11'd1055;

  logic        sgn;
  logic [10:0] ex;
  logic [51:0] man;
  logic [83:0] wide;
  logic [4:0]  sh;
  logic [31:0] intp;
  logic        grd, stk, big, raw, rup;
  logic [32:0] mag;

  assign sgn = op_i[63];
  assign ex  = op_i[62:52];
  assign man = op_i[51:0];
  assign sh  = 5'(ex - BIAS);

  always_comb begin
    intp = '0;
    grd  = 1'b0;
    stk  = 1'b0;
    big  = 1'b0;
    wide = {31'b0, 1'b1, man} << sh;
    if (ex >= EXP_LIM) begin
      big = 1'b1;                       // covers NaN, infinity, >= 2^32
    end else if (ex >= BIAS) begin
      intp = wide[83:52];
      grd  = wide[51];
      stk  = |wide[50:0];
    end else if (ex == BIAS - 11'd1) begin
      grd  = 1'b1;                      // magnitude in [0.5, 1)
      stk  = |man;
    end else begin
      stk  = (ex != 11'd0) || (|man);   // below 0.5, or zero
    end
    raw = grd | stk;
    case (rc_i)
      RC_NEAR: rup = grd & (stk | intp[0]);
      RC_DOWN: rup = sgn & raw;
      RC_UP:   rup = ~sgn & raw;
      default: rup = 1'b0;
    endcase
    mag   = {1'b0, intp} + {32'b0, rup};
    inv_o = big | mag[32] | (sgn & (mag != 33'd0));
    inx_o = ~inv_o & raw;
    if (inv_o)    res_o = '1;
    else if (sgn) res_o = '0;
    else          res_o = mag[31:0];
  end
endmodule

// File: rtl/pcv_u32_unit.sv
module pcv_u32_unit
  import pcv_pkg::*;
#(
  parameter int unsigned NLANE = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid_i,
  input  logic [NLANE*FP_W-1:0]  src_i,
  input  logic                   src_mem_i,
  input  logic                   bcast_i,
  input  logic [1:0]             vlen_i,
  input  logic [1:0]             erc_i,
  input  logic [1:0]             grc_i,
  input  logic [NLANE-1:0]       wmask_i,
  input  logic                   mask_en_i,
  input  logic                   zero_en_i,
  input  logic [NLANE*FP_W-1:0]  old_dst_i,
  input  logic [3:0]             rsvd_i,
  output logic                   out_valid_o,
  output logic [NLANE*FP_W-1:0]  dst_o,
  output logic                   inv_o,
  output logic                   inx_o,
  output logic                   ud_o
);
  localparam int unsigned SRC_W = NLANE * FP_W;
  localparam int unsigned HALF  = SRC_W / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [NLANE-1:0] lane_on;
  pcv_rc_e          rc_eff;
  logic             bmem, ud;

  pcv_ctl #(.NLANE(NLANE)) ctl_i (
    .vlen_i(vlen_i), .src_mem_i(src_mem_i), .bcast_i(bcast_i),
    .erc_i(erc_i), .grc_i(grc_i), .rsvd_i(rsvd_i),
    .lane_on_o(lane_on), .rc_o(rc_eff), .bmem_o(bmem), .ud_o(ud)
  );

  logic [INT_W-1:0] lane_res [NLANE];
  logic [NLANE-1:0] lane_inv, lane_inx;

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    logic [FP_W-1:0] lane_src;
    assign lane_src = bmem ? src_i[FP_W-1:0] : src_i[j*FP_W +: FP_W];
    pcv_lane_cvt cvt_i (
      .op_i(lane_src), .rc_i(rc_eff),
      .res_o(lane_res[j]), .inv_o(lane_inv[j]), .inx_o(lane_inx[j])
    );
  end

  logic [SRC_W-1:0] nxt_dst;
  logic             nxt_inv, nxt_inx;
  logic [NLANE-1:0] take;

  always_comb begin
    nxt_dst = '0;
    take    = lane_on & (mask_en_i ? wmask_i : {NLANE{1'b1}});
    for (int j = 0; j < NLANE; j++) begin
      if (take[j])                      nxt_dst[j*INT_W +: INT_W] = lane_res[j];
      else if (lane_on[j] && !zero_en_i) nxt_dst[j*INT_W +: INT_W] = old_dst_i[j*INT_W +: INT_W];
    end
    nxt_inv = |(lane_inv & take);
    nxt_inx = |(lane_inx & take);
    if (ud) begin
      nxt_dst = old_dst_i;
      nxt_inv = 1'b0;
      nxt_inx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid_o <= 1'b0;
      dst_o       <= '0;
      inv_o       <= 1'b0;
      inx_o       <= 1'b0;
      ud_o        <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        dst_o <= nxt_dst;
        inv_o <= nxt_inv;
        inx_o <= nxt_inx;
        ud_o  <= ud;
      end
    end
  end

  assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid_i |=> out_valid_o);
  assert_ud_keep_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid_o && ud_o) |-> (dst_o == $past(old_dst_i)));
  assert_ud_quiet_R11: assert property (@(posedge clk) disable iff (!rst_q)
    ud_o |-> (!inv_o && !inx_o));
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid_o && !ud_o) |-> (dst_o[SRC_W-1:HALF] == '0));
  assert_merge_keep_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid_o && !ud_o && $past(mask_en_i && !zero_en_i && !wmask_i[0]))
      |-> (dst_o[INT_W-1:0] == $past(old_dst_i[INT_W-1:0])));
  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid_o && !ud_o && $past(mask_en_i && zero_en_i && !wmask_i[0]))
      |-> (dst_o[INT_W-1:0] == '0));
endmodule

// File: tb/pcv_u32_unit_tb_top.sv
module pcv_u32_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         in_valid;
  logic [511:0] src, old_dst;
  logic         src_mem, bcast, mask_en, zero_en;
  logic [1:0]   vlen, erc, grc;
  logic [7:0]   wmask;
  logic [3:0]   rsvd;
  logic         out_valid, inv, inx, ud;
  logic [511:0] dst;

  pcv_u32_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .src_i(src),
    .src_mem_i(src_mem), .bcast_i(bcast), .vlen_i(vlen), .erc_i(erc),
    .grc_i(grc), .wmask_i(wmask), .mask_en_i(mask_en), .zero_en_i(zero_en),
    .old_dst_i(old_dst), .rsvd_i(rsvd), .out_valid_o(out_valid),
    .dst_o(dst), .inv_o(inv), .inx_o(inx), .ud_o(ud)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [511:0] e_dst;
  logic         e_inv, e_inx, e_ud;

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] d(input real v);
    return $realtobits(v);
  endfunction

  function automatic void ref_lane(input logic [63:0] x, input logic [1:0] rc,
                                   output logic [31:0] r, output logic iv, output logic ix);
    real v, fl, fr, q;
    iv = 1'b0; ix = 1'b0; r = '0;
    if (x[62:52] == 11'h7FF) begin iv = 1'b1; r = '1; return; end
    v  = $bitstoreal(x);
    fl = $floor(v);
    fr = v - fl;
    case (rc)
      2'b00: begin
        if (fr > 0.5) q = fl + 1.0;
        else if (fr < 0.5) q = fl;
        else q = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
      end
      2'b01: q = fl;
      2'b10: q = $ceil(v);
      default: q = (v < 0.0) ? $ceil(v) : fl;
    endcase
    if (q < 0.0 || q > 4294967295.0) begin iv = 1'b1; r = '1; end
    else begin r = 32'(longint'(q)); ix = (q != v); end
  endfunction

  function automatic void ref_all();
    int cnt;
    logic [1:0] rc;
    cnt = (vlen == 2'b00) ? 2 : (vlen == 2'b01) ? 4 : 8;
    rc  = (!src_mem && bcast && vlen[1]) ? erc : grc;
    e_dst = '0; e_inv = 1'b0; e_inx = 1'b0;
    e_ud  = (rsvd != 4'b1111);
    for (int j = 0; j < cnt; j++) begin
      logic [63:0] x;
      logic [31:0] r;
      logic iv, ix;
      x = (src_mem && bcast) ? src[63:0] : src[64*j +: 64];
      ref_lane(x, rc, r, iv, ix);
      if (!mask_en || wmask[j]) begin
        e_dst[32*j +: 32] = r;
        e_inv |= iv;
        e_inx |= ix;
      end else if (!zero_en) begin
        e_dst[32*j +: 32] = old_dst[32*j +: 32];
      end
    end
    if (e_ud) begin e_dst = old_dst; e_inv = 1'b0; e_inx = 1'b0; end
  endfunction

  task automatic set_plain();
    src_mem = 0; bcast = 0; vlen = 2'b10; erc = 2'b00; grc = 2'b00;
    wmask = '1; mask_en = 0; zero_en = 0; rsvd = 4'b1111;
    old_dst = {16{32'hA5A5_0000}};
  endtask

  task automatic fire(input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    ref_all();
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {511'b0, out_valid}, 512'd1);
    chk({tag, " dst"}, dst, e_dst);
    chk({tag, " inv"}, {511'b0, inv}, {511'b0, e_inv});
    chk({tag, " inx"}, {511'b0, inx}, {511'b0, e_inx});
    chk({tag, " ud"},  {511'b0, ud},  {511'b0, e_ud});
  endtask

  task automatic t_reset();
    chk("R13 reset valid", {511'b0, out_valid}, '0);
    chk("R13 reset dst", dst, '0);
    chk("R13 reset flags", {509'b0, inv, inx, ud}, '0);
  endtask

  task automatic t_round();
    set_plain();
    src = '0;
    src[63:0]    = d(2.5);
    src[127:64]  = d(3.5);
    src[191:128] = d(-0.0);
    src[255:192] = d(7.0);
    src[319:256] = d(1234567.75);
    src[383:320] = d(0.25);
    src[447:384] = d(4294967295.0);
    src[511:448] = d(1.0e-310);
    for (int m = 0; m < 4; m++) begin
      grc = 2'(m);
      fire($sformatf("R2 R4 mode%0d", m));
      chk($sformatf("R2 lane0 2.5 mode%0d", m), {480'b0, dst[31:0]},
          {480'b0, (m == 2) ? 32'd3 : 32'd2});
    end
  endtask

  task automatic t_invalid();
    set_plain();
    src[63:0]    = 64'h7FF8_0000_0000_0000;
    src[127:64]  = 64'h7FF0_0000_0000_0000;
    src[191:128] = d(4294967296.0);
    src[255:192] = d(-1.0);
    src[319:256] = d(4294967295.4);
    src[383:320] = d(-0.3);
    src[447:384] = d(-0.5);
    src[511:448] = d(4294967295.5);
    for (int m = 0; m < 4; m++) begin
      grc = 2'(m);
      fire($sformatf("R3 R4 special mode%0d", m));
    end
    grc = 2'b00;
    src = {8{d(-0.3)}};
    fire("R4 negative to zero");
    chk("R4 neg zero result", dst, '0);
    chk("R4 neg zero inexact", {511'b0, inx}, 512'd1);
  endtask

  task automatic t_mask();
    set_plain();
    src = '0;
    for (int j = 0; j < 8; j++) src[64*j +: 64] = d(real'(j) + 10.0);
    src[127:64] = 64'h7FF8_0000_0000_0001;
    src[255:192] = d(5.5);
    mask_en = 1; wmask = 8'b1111_0101;
    fire("R5 R6 R12 merge");
    chk("R6 lane1 kept", {480'b0, dst[63:32]}, {480'b0, 32'hA5A5_0000});
    chk("R12 nan masked", {510'b0, inv, inx}, '0);
    zero_en = 1;
    fire("R7 zeroing");
    chk("R7 lane3 zero", {480'b0, dst[127:96]}, '0);
    mask_en = 0; wmask = 8'h00;
    fire("R5 mask off ignores bits");
    chk("R5 nan now counted", {511'b0, inv}, 512'd1);
  endtask

  task automatic t_vlen();
    set_plain();
    for (int j = 0; j < 8; j++) src[64*j +: 64] = d(real'(j) + 0.5);
    src[319:256] = 64'h7FF0_0000_0000_0000;
    for (int v = 0; v < 4; v++) begin
      vlen = 2'(v);
      fire($sformatf("R1 R8 vlen%0d", v));
    end
    vlen = 2'b00;
    fire("R8 short");
    chk("R8 short upper zero", {64'b0, dst[511:64]}, '0);
    chk("R12 out-of-range inf quiet", {511'b0, inv}, '0);
  endtask

  task automatic t_override();
    set_plain();
    src = {8{d(2.5)}};
    bcast = 1; erc = 2'b10; grc = 2'b00;
    fire("R9 reg full override");
    chk("R9 override up", {480'b0, dst[255:224]}, {480'b0, 32'd3});
    vlen = 2'b01;
    fire("R9 reg short no override");
    chk("R9 short global", {480'b0, dst[31:0]}, {480'b0, 32'd2});
    vlen = 2'b10; src_mem = 1;
    fire("R9 mem no override");
    chk("R9 mem global", {480'b0, dst[31:0]}, {480'b0, 32'd2});
  endtask

  task automatic t_bcast();
    set_plain();
    for (int j = 0; j < 8; j++) src[64*j +: 64] = d(real'(j) * 100.0 + 9.0);
    src_mem = 1; bcast = 1;
    fire("R10 mem broadcast");
    chk("R10 lane7 from low", {480'b0, dst[255:224]}, {480'b0, 32'd9});
    src_mem = 0; vlen = 2'b00;
    fire("R10 reg no broadcast");
    chk("R10 lane1 own", {480'b0, dst[63:32]}, {480'b0, 32'd109});
  endtask

  task automatic t_ud();
    set_plain();
    src = {8{64'h7FF8_0000_0000_0000}};
    old_dst = {16{32'h1234_5678}};
    rsvd = 4'b0111;
    fire("R11 reserved bad");
    chk("R11 passthru", dst, {16{32'h1234_5678}});
    rsvd = 4'b1111;
    fire("R11 reserved good");
  endtask

  task automatic t_hold();
    logic [511:0] snap;
    set_plain();
    src = {8{d(42.0)}};
    fire("R13 load");
    snap = dst;
    src = {8{d(7.0)}};
    @(negedge clk);
    @(negedge clk);
    chk("R13 idle valid low", {511'b0, out_valid}, '0);
    chk("R13 idle hold", dst, snap);
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 10)
      0: return 64'h7FF8_0000_0000_0000;
      1: return {$urandom % 2 == 0 ? 1'b0 : 1'b1, 11'h7FF, 52'b0};
      2: return d(4294967295.0 + real'($urandom % 4) * 0.25);
      3: return d(-real'($urandom % 8) * 0.25);
      4: return d(real'($urandom % 64) * 0.5);
      5: return {$urandom, $urandom};
      6: return {12'h000, 20'($urandom), $urandom};
      default: return d(real'($urandom) / 7.0);
    endcase
  endfunction

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      for (int j = 0; j < 8; j++) src[64*j +: 64] = pick();
      old_dst = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                 $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      src_mem = 1'($urandom); bcast = 1'($urandom); vlen = 2'($urandom);
      erc = 2'($urandom); grc = 2'($urandom); wmask = 8'($urandom);
      mask_en = 1'($urandom); zero_en = 1'($urandom);
      rsvd = ($urandom % 8 == 0) ? 4'($urandom) : 4'b1111;
      fire("R1 R2 R3 R12 random");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    in_valid = 1'b0;
    set_plain();
    src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_round();
    t_invalid();
    t_mask();
    t_vlen();
    t_override();
    t_bcast();
    t_ud();
    t_hold();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule